// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns message-signalled interrupt writes into entries of per-group circular event queues held in system memory. An upstream port hands it the offset of each posted write inside a small MSI window, along with the 32-bit write data. The block picks a target group from that offset. It writes the data word into the next free slot of that group's 64-entry ring, and only after the memory write has been issued does it advance the ring's tail pointer. Each group drives its own level interrupt line, which stays high while its ring holds unconsumed entries.

Software drains a ring through a small register port. It reads the tail, processes the entries from head up to tail, and writes the new head back. Two layouts are available at run time. In the packed layout, every 32-bit word of the window selects a group, and all rings sit back to back in one 4 KB page. In the paged layout, every 4 KB page of the window selects a group, and each ring has its own programmable 4 KB page. A ring that is full drops the incoming write and records the loss in a sticky per-group flag.

Top module: `msi_eventq_ctrl`

## Requirements
- R1: After reset, every control, head, tail and overflow register reads 0, the layout register reads 0 (packed), no memory write is issued and every interrupt line is low.
- R2: An inbound write accepted for group g drives `mem_wr_en` high in the following cycle, with `mem_wr_data` equal to the write data (bits [5:0] carry the vector number). The word-aligned slot address is that of the ring's current tail slot. The tail register reads the old value in that cycle and the old value plus one from the next cycle on.
- R3: Head and tail are 6-bit indices. A tail at 63 advances to 0, and the slot after index 63 is index 0.
- R4: When the slot to be written is one before head (slot+1 mod 64 equals head), the write is dropped, the tail does not move, and the group's overflow flag (bit 0 of register +0x0C) becomes 1. The flag stays 1 until software writes 1 to bit 0 of that register.
- R5: Interrupt line g is high exactly when control bits 0 (queue enable), 1 (event interrupt) and 11 (interrupt enable) are all set, the legacy gate bit g is set, and head differs from tail. Writing head equal to tail drops it in the next cycle.
- R6: In packed layout (layout register 0xE4 bit 0 = 0), offset bits [1:0] must be 0, group = offset/4, and the slot address is page0 + g*256 + slot*4, where page0 is the page register of group 0.
- R7: In paged layout (0xE4 bit 0 = 1), group = offset/4096 and the slot address is page_g + slot*4. Page registers at +0x10 and +0x14 hold address bits [31:12] and [63:32], and bits [11:0] read as 0.
- R8: A write to a group whose queue enable bit is 0, or a write whose decoded group is 6 or more, issues no memory write, leaves every tail unchanged and sets no overflow flag.
- R9: Head (+0x04) is written only by software and holds 6 bits. Writes to the tail register (+0x08) are ignored.
- R10: The legacy gate register at 0xE0 holds one bit per group. Clearing bit g forces interrupt g low even while entries are pending.
- R11: The control register (+0x00) stores only bits 0, 1 and 11, and reads every other bit as 0.

Group g's registers sit at byte address g*32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound MSI write strobe |
| msi_offset | input | WIN_AW | Byte offset of the write inside the MSI window |
| msi_data | input | 32 | MSI write data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_wr_en | output | 1 | Queue memory write strobe |
| mem_wr_addr | output | MEM_AW | Queue memory byte address |
| mem_wr_data | output | 32 | Queue entry written |
| irq_out | output | NUM_GRP | Per-group level interrupt |

## Verification
The assertions take for granted that queue memory accepts every write in the cycle it is issued, and that at most one inbound write arrives per cycle. They also assume software writes the head register only with indices it has actually consumed. The stimulus keeps to this: the bench issues one strobe per cycle and never stalls the memory port. Head values it writes always lie between the current head and the model's tail, and the bench drives no register write on a cycle where the model would also accept an inbound write for the same group's page.

// File: rtl/eq_pkg.sv
package eq_pkg;
   // control register bit positions (software-visible encoding)
   localparam int CTL_QEN_BIT = 0;
   localparam int CTL_EVT_BIT = 1;
   localparam int CTL_IEN_BIT = 11;

   // register select within a group's 32-byte slice
   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_HEAD = 3'd1;
   localparam logic [2:0] SEL_TAIL = 3'd2;
   localparam logic [2:0] SEL_OVF  = 3'd3;
   localparam logic [2:0] SEL_PGLO = 3'd4;
   localparam logic [2:0] SEL_PGHI = 3'd5;

   // global slice
   localparam logic [2:0] GLB_SLICE  = 3'd7;
   localparam logic [2:0] SEL_LEGACY = 3'd0;
   localparam logic [2:0] SEL_LAYOUT = 3'd1;

   typedef struct packed {
      logic ien;
      logic evt;
      logic qen;
   } ctl_t;
endpackage

// File: rtl/eq_route.sv
module eq_route #(
   parameter int NUM_GRP = 6,
   parameter int WIN_AW  = 16,
   parameter int GI_W    = 3
) (
   input  logic [WIN_AW-1:0] offset,
   input  logic              paged,
   output logic [GI_W-1:0]   grp,
   output logic              hit
);
   logic [WIN_AW-3:0]  word_idx;
   logic [WIN_AW-13:0] page_idx;

   assign word_idx = offset[WIN_AW-1:2];
   assign page_idx = offset[WIN_AW-1:12];

   always_comb begin
      if (paged) begin
         grp = page_idx[GI_W-1:0];
         hit = (32'(page_idx) < 32'(NUM_GRP));
      end else begin
         grp = word_idx[GI_W-1:0];
         hit = (32'(word_idx) < 32'(NUM_GRP)) && (offset[1:0] == 2'b00);
      end
   end
endmodule

// File: rtl/eq_addr_gen.sv
module eq_addr_gen #(
   parameter int GI_W   = 3,
   parameter int IDX_W  = 6,
   parameter int MEM_AW = 64
) (
   input  logic              paged,
   input  logic [GI_W-1:0]   grp,
   input  logic [IDX_W-1:0]  slot,
   input  logic [MEM_AW-13:0] shared_page,
   input  logic [MEM_AW-13:0] own_page,
   output logic [MEM_AW-1:0] addr
);
   localparam int RING_SHIFT = IDX_W + 2;

   logic [MEM_AW-1:0] slot_off;
   logic [MEM_AW-1:0] ring_off;

   assign slot_off = MEM_AW'(slot) << 2;
   assign ring_off = MEM_AW'(grp) << RING_SHIFT;

   always_comb begin
      if (paged) addr = {own_page, 12'h000} + slot_off;
      else       addr = {shared_page, 12'h000} + ring_off + slot_off;
   end
endmodule

// File: rtl/eq_grp_state.sv
module eq_grp_state
   import eq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int PAGE_W = 52
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              head_we,
   input  logic              ovf_we,
   input  logic              pglo_we,
   input  logic              pghi_we,
   input  logic [31:0]       wdata,
   input  logic              push,
   input  logic              ovf_set,
   output ctl_t              ctl,
   output logic [IDX_W-1:0]  head,
   output logic [IDX_W-1:0]  tail,
   output logic              ovf,
   output logic [PAGE_W-1:0] page
);
   localparam int LO_W = 20;
   localparam int HI_W = PAGE_W - LO_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= '0;
         head <= '0;
         tail <= '0;
         ovf  <= 1'b0;
         page <= '0;
      end else begin
         if (ctl_we) begin
            ctl.qen <= wdata[CTL_QEN_BIT];
            ctl.evt <= wdata[CTL_EVT_BIT];
            ctl.ien <= wdata[CTL_IEN_BIT];
         end
         if (head_we) head <= wdata[IDX_W-1:0];
         if (push)    tail <= tail + IDX_W'(1);
         if (ovf_set)                 ovf <= 1'b1;
         else if (ovf_we && wdata[0]) ovf <= 1'b0;
         if (pglo_we) page[LO_W-1:0]      <= wdata[31:12];
         if (pghi_we) page[PAGE_W-1:LO_W] <= wdata[HI_W-1:0];
      end
   end
endmodule

// File: rtl/msi_eventq_ctrl.sv
module msi_eventq_ctrl
   import eq_pkg::*;
#(
   parameter int NUM_GRP     = 6,
   parameter int IDX_W       = 6,
   parameter int WIN_AW      = 16,
   parameter int MEM_AW      = 64,
   parameter bit LEGACY_GATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msi_valid,
   input  logic [WIN_AW-1:0]  msi_offset,
   input  logic [31:0]        msi_data,
   input  logic               reg_wr_en,
   input  logic [7:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_wr_en,
   output logic [MEM_AW-1:0]  mem_wr_addr,
   output logic [31:0]        mem_wr_data,
   output logic [NUM_GRP-1:0] irq_out
);
   localparam int GI_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
   localparam int PAGE_W = MEM_AW - 12;

   generate
      if (NUM_GRP < 1 || NUM_GRP > 7) begin : g_chk_grp
         $error("NUM_GRP must lie in 1..7");
      end
      if (IDX_W < 2 || IDX_W > 10) begin : g_chk_idx
         $error("IDX_W must lie in 2..10");
      end
      if (WIN_AW < 15 || WIN_AW > 32) begin : g_chk_win
         $error("WIN_AW must lie in 15..32");
      end
      if (MEM_AW < 33 || MEM_AW > 64) begin : g_chk_mem
         $error("MEM_AW must lie in 33..64");
      end
   endgenerate

   // ---------------- register decode ----------------
   logic [2:0] reg_slice;
   logic [2:0] reg_sel;
   logic       reg_aligned;

   assign reg_slice   = reg_addr[7:5];
   assign reg_sel     = reg_addr[4:2];
   assign reg_aligned = (reg_addr[1:0] == 2'b00);

   logic [NUM_GRP-1:0] legacy_q;
   logic               paged_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         legacy_q <= '0;
         paged_q  <= 1'b0;
      end else if (reg_wr_en && reg_aligned && reg_slice == GLB_SLICE) begin
         if (reg_sel == SEL_LEGACY) legacy_q <= reg_wdata[NUM_GRP-1:0];
         if (reg_sel == SEL_LAYOUT) paged_q  <= reg_wdata[0];
      end
   end

   // ---------------- per-group state ----------------
   ctl_t               ctl_a  [NUM_GRP];
   logic [IDX_W-1:0]   head_a [NUM_GRP];
   logic [IDX_W-1:0]   tail_a [NUM_GRP];
   logic [PAGE_W-1:0]  page_a [NUM_GRP];
   logic [NUM_GRP-1:0] ovf_vec;
   logic [NUM_GRP-1:0] push_vec;
   logic [NUM_GRP-1:0] drop_vec;
   logic [NUM_GRP*IDX_W-1:0] tail_flat;
   logic [NUM_GRP*IDX_W-1:0] head_flat;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         logic slice_we;
         logic ring_irq;

         assign slice_we = reg_wr_en && reg_aligned && (reg_slice == 3'(g));

         eq_grp_state #(
            .IDX_W (IDX_W),
            .PAGE_W(PAGE_W)
         ) i_state (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_we (slice_we && reg_sel == SEL_CTRL),
            .head_we(slice_we && reg_sel == SEL_HEAD),
            .ovf_we (slice_we && reg_sel == SEL_OVF),
            .pglo_we(slice_we && reg_sel == SEL_PGLO),
            .pghi_we(slice_we && reg_sel == SEL_PGHI),
            .wdata  (reg_wdata),
            .push   (push_vec[g]),
            .ovf_set(drop_vec[g]),
            .ctl    (ctl_a[g]),
            .head   (head_a[g]),
            .tail   (tail_a[g]),
            .ovf    (ovf_vec[g]),
            .page   (page_a[g])
         );

         assign ring_irq = ctl_a[g].qen && ctl_a[g].evt && ctl_a[g].ien &&
                           (head_a[g] != tail_a[g]);

         if (LEGACY_GATE) begin : g_gated
            assign irq_out[g] = ring_irq && legacy_q[g];
         end else begin : g_open
            assign irq_out[g] = ring_irq;
         end

         assign tail_flat[g*IDX_W +: IDX_W] = tail_a[g];
         assign head_flat[g*IDX_W +: IDX_W] = head_a[g];
      end
   endgenerate

   // ---------------- ingress ----------------
   logic [GI_W-1:0]   in_grp;
   logic              in_hit;
   logic [GI_W-1:0]   grp_sel;
   logic              in_flight;
   logic [IDX_W-1:0]  slot;
   logic [IDX_W-1:0]  slot_next;
   logic              ring_full;
   logic              accept;
   logic              drop;
   logic [MEM_AW-1:0] slot_addr;

   logic              pend_q;
   logic [GI_W-1:0]   pend_grp_q;
   logic [MEM_AW-1:0] pend_addr_q;
   logic [31:0]       pend_data_q;

   eq_route #(
      .NUM_GRP(NUM_GRP),
      .WIN_AW (WIN_AW),
      .GI_W   (GI_W)
   ) i_route (
      .offset(msi_offset),
      .paged (paged_q),
      .grp   (in_grp),
      .hit   (in_hit)
   );

   assign grp_sel   = in_hit ? in_grp : '0;
   assign in_flight = pend_q && (pend_grp_q == grp_sel);
   assign slot      = tail_a[grp_sel] + IDX_W'(in_flight);
   assign slot_next = slot + IDX_W'(1);
   assign ring_full = (slot_next == head_a[grp_sel]);
   assign accept    = msi_valid && in_hit && ctl_a[grp_sel].qen && !ring_full;
   assign drop      = msi_valid && in_hit && ctl_a[grp_sel].qen &&  ring_full;

   eq_addr_gen #(
      .GI_W  (GI_W),
      .IDX_W (IDX_W),
      .MEM_AW(MEM_AW)
   ) i_addr (
      .paged      (paged_q),
      .grp        (grp_sel),
      .slot       (slot),
      .shared_page(page_a[0]),
      .own_page   (page_a[grp_sel]),
      .addr       (slot_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_grp_q  <= '0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
      end else begin
         pend_q <= accept;
         if (accept) begin
            pend_grp_q  <= grp_sel;
            pend_addr_q <= slot_addr;
            pend_data_q <= msi_data;
         end
      end
   end

   // tail moves on the edge that ends the memory write cycle
   always_comb begin
      push_vec = '0;
      drop_vec = '0;
      if (pend_q) push_vec[pend_grp_q] = 1'b1;
      if (drop)   drop_vec[grp_sel]    = 1'b1;
   end

   assign mem_wr_en   = pend_q;
   assign mem_wr_addr = pend_addr_q;
   assign mem_wr_data = pend_data_q;

   // ---------------- read mux ----------------
   always_comb begin
      logic [GI_W-1:0] rg;
      rg        = GI_W'(reg_slice);
      reg_rdata = '0;
      if (reg_aligned) begin
         if (reg_slice == GLB_SLICE) begin
            if (reg_sel == SEL_LEGACY) reg_rdata[NUM_GRP-1:0] = legacy_q;
            if (reg_sel == SEL_LAYOUT) reg_rdata[0] = paged_q;
         end else if (32'(reg_slice) < 32'(NUM_GRP)) begin
            case (reg_sel)
               SEL_CTRL: begin
                  reg_rdata[CTL_QEN_BIT] = ctl_a[rg].qen;
                  reg_rdata[CTL_EVT_BIT] = ctl_a[rg].evt;
                  reg_rdata[CTL_IEN_BIT] = ctl_a[rg].ien;
               end
               SEL_HEAD: reg_rdata[IDX_W-1:0] = head_a[rg];
               SEL_TAIL: reg_rdata[IDX_W-1:0] = tail_a[rg];
               SEL_OVF:  reg_rdata[0] = ovf_vec[rg];
               SEL_PGLO: reg_rdata = {page_a[rg][19:0], 12'h000};
               SEL_PGHI: reg_rdata = 32'(page_a[rg][PAGE_W-1:20]);
               default:  reg_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/eq_ctrl_checker.sv
module eq_ctrl_checker #(
   parameter int NUM_GRP = 6,
   parameter int IDX_W   = 6,
   parameter int MEM_AW  = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     msi_valid,
   input logic                     mem_wr_en,
   input logic [MEM_AW-1:0]        mem_wr_addr,
   input logic [NUM_GRP-1:0]       irq_out,
   input logic [NUM_GRP-1:0]       ovf_vec,
   input logic [NUM_GRP*IDX_W-1:0] tail_flat,
   input logic [NUM_GRP*IDX_W-1:0] head_flat
);
   // R2: a tail only moves after its entry was written to memory
   assert_tail_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_flat != $past(tail_flat)) |-> $past(mem_wr_en));

   // R2: every memory write stems from an inbound write
   assert_write_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(msi_valid));

   // R2: entries are word aligned
   assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wr_addr[1:0] == 2'b00));

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
         // R3: tail steps by exactly one, wrapping modulo the ring size
         assert_tail_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tail_flat[g*IDX_W +: IDX_W] != $past(tail_flat[g*IDX_W +: IDX_W])) |->
            (tail_flat[g*IDX_W +: IDX_W] == IDX_W'($past(tail_flat[g*IDX_W +: IDX_W]) + 1)));

         // R4: an overflow flag only rises after an inbound write
         assert_ovf_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_vec[g]) |-> $past(msi_valid));

         // R5: an interrupt means the ring holds entries
         assert_irq_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[g] |-> (head_flat[g*IDX_W +: IDX_W] != tail_flat[g*IDX_W +: IDX_W]));
      end
   endgenerate
endmodule

bind msi_eventq_ctrl eq_ctrl_checker #(
   .NUM_GRP(NUM_GRP),
   .IDX_W  (IDX_W),
   .MEM_AW (MEM_AW)
) i_eq_ctrl_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .msi_valid  (msi_valid),
   .mem_wr_en  (mem_wr_en),
   .mem_wr_addr(mem_wr_addr),
   .irq_out    (irq_out),
   .ovf_vec    (ovf_vec),
   .tail_flat  (tail_flat),
   .head_flat  (head_flat)
);

// File: tb/test_msi_eventq_ctrl.sv
`timescale 1ns/1ps
module test_msi_eventq_ctrl;
   localparam int NG = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_valid = 1'b0;
   logic [15:0] msi_offset = '0;
   logic [31:0] msi_data = '0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_wr_en;
   logic [63:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic [NG-1:0] irq_out;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   msi_eventq_ctrl i_msi_eventq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .msi_valid(msi_valid), .msi_offset(msi_offset), .msi_data(msi_data),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .irq_out(irq_out)
   );

   // ---------------- behavioural reference model ----------------
   int          m_head [NG];
   int          m_tail [NG];
   logic [31:0] m_ctl  [NG];
   bit          m_ovf  [NG];
   logic [63:0] m_page [NG];
   logic [NG-1:0] m_leg;
   bit          m_paged;
   bit          m_pend;
   int          m_pgrp;
   logic [63:0] m_paddr;
   logic [31:0] m_pdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NG; g++) begin
            m_head[g] = 0; m_tail[g] = 0; m_ctl[g] = 0; m_ovf[g] = 0; m_page[g] = 0;
         end
         m_leg = 0; m_paged = 0; m_pend = 0; m_pgrp = 0; m_paddr = 0; m_pdata = 0;
      end else begin
         bit          n_pend;
         int          n_grp;
         logic [63:0] n_addr;
         int          ovf_grp;
         int          g;
         int          te;
         n_pend = 0; n_grp = 0; n_addr = 0; ovf_grp = -1;
         if (msi_valid) begin
            if (m_paged) g = int'(msi_offset) / 4096;
            else if (msi_offset[1:0] == 2'b00) g = int'(msi_offset) / 4;
            else g = NG;
            if (g < NG && m_ctl[g][0]) begin
               te = (m_tail[g] + ((m_pend && m_pgrp == g) ? 1 : 0)) % 64;
               if ((te + 1) % 64 == m_head[g]) ovf_grp = g;
               else begin
                  n_pend = 1; n_grp = g;
                  if (m_paged) n_addr = m_page[g] + 64'(te * 4);
                  else         n_addr = m_page[0] + 64'(g * 256 + te * 4);
               end
            end
         end
         if (m_pend) m_tail[m_pgrp] = (m_tail[m_pgrp] + 1) % 64;
         if (reg_wr_en && reg_addr[1:0] == 2'b00) begin
            int rg, rs;
            rg = int'(reg_addr[7:5]); rs = int'(reg_addr[4:2]);
            if (rg == 7) begin
               if (rs == 0) m_leg = reg_wdata[NG-1:0];
               if (rs == 1) m_paged = reg_wdata[0];
            end else if (rg < NG) begin
               case (rs)
                  0: m_ctl[rg] = reg_wdata & 32'h0000_0803;
                  1: m_head[rg] = int'(reg_wdata[5:0]);
                  3: if (reg_wdata[0]) m_ovf[rg] = 0;
                  4: m_page[rg][31:12] = reg_wdata[31:12];
                  5: m_page[rg][63:32] = reg_wdata;
                  default: ;
               endcase
            end
         end
         if (ovf_grp >= 0) m_ovf[ovf_grp] = 1;
         m_pend = n_pend; m_pgrp = n_grp; m_paddr = n_addr;
         if (n_pend) m_pdata = msi_data;
      end
   end

   function automatic logic [NG-1:0] exp_irq();
      logic [NG-1:0] v;
      for (int g = 0; g < NG; g++)
         v[g] = m_ctl[g][0] && m_ctl[g][1] && m_ctl[g][11] && m_leg[g] &&
                (m_head[g] != m_tail[g]);
      return v;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   bit run_cmp = 0;
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         check("R2 mem_wr_en per cycle", 64'(mem_wr_en), 64'(m_pend));
         if (m_pend) begin
            check("R2/R6/R7 mem_wr_addr per cycle", mem_wr_addr, m_paddr);
            check("R2 mem_wr_data per cycle", 64'(mem_wr_data), 64'(m_pdata));
         end
         check("R5 irq_out per cycle", 64'(irq_out), 64'(exp_irq()));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr_en = 0;
   endtask

   task automatic msi(input logic [15:0] off, input logic [31:0] d);
      @(negedge clk); msi_valid = 1; msi_offset = off; msi_data = d;
      @(negedge clk); msi_valid = 0;
   endtask

   task automatic msi_burst(input logic [15:0] off, input int n, input logic [31:0] d0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); msi_valid = 1; msi_offset = off; msi_data = d0 + 32'(i);
      end
      @(negedge clk); msi_valid = 0;
   endtask

   task automatic peek(string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a; #1;
      check(tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic reg_chk(string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk); peek(tag, a, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // ---------------- scenario ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      run_cmp = 1;
      // R1 reset state
      reg_chk("R1 ctrl0 reset", 8'h00, 32'h0);
      peek("R1 head3 reset", 8'h64, 32'h0);
      peek("R1 tail5 reset", 8'hA8, 32'h0);
      peek("R1 ovf2 reset", 8'h4C, 32'h0);
      peek("R1 layout reset", 8'hE4, 32'h0);
      check("R1 irq reset", 64'(irq_out), 64'h0);
      check("R1 mem_wr_en reset", 64'(mem_wr_en), 64'h0);

      // R8 disabled queue ignores writes
      msi(16'h0000, 32'h11);
      check("R8 no memory write on disabled queue", 64'(mem_wr_en), 64'h0);
      reg_chk("R8 tail0 unchanged", 8'h08, 32'h0);
      peek("R8 ovf0 unchanged", 8'h0C, 32'h0);

      // setup: page0, enables, legacy gate
      reg_wr(8'h10, 32'h2345_6789);
      reg_wr(8'h14, 32'h0000_0001);
      reg_chk("R7 page low bits read zero", 8'h10, 32'h2345_6000);
      for (int g = 0; g < NG; g++) reg_wr(8'(g * 32), 32'hFFFF_FFFF);
      reg_chk("R11 ctrl keeps bits 0,1,11", 8'h20, 32'h0000_0803);
      reg_wr(8'hE0, 32'h3F);

      // R2 / R6 single write to group 1
      msi(16'h0004, 32'hABC0_0007);
      check("R2 mem_wr_en after accept", 64'(mem_wr_en), 64'h1);
      check("R6 packed slot address", mem_wr_addr, 64'h1_2345_6100);
      check("R2 entry data", 64'(mem_wr_data), 64'hABC0_0007);
      check("R2 vector bits", 64'(mem_wr_data[5:0]), 64'h7);
      peek("R2 tail hidden during write", 8'h28, 32'h0);
      reg_chk("R2 tail visible after write", 8'h28, 32'h1);
      check("R5 irq1 high with pending entry", 64'(irq_out[1]), 64'h1);

      // R9 tail read-only, head writable
      reg_wr(8'h28, 32'h0000_0020);
      peek("R9 tail write ignored", 8'h28, 32'h1);
      // R10 legacy gate
      reg_wr(8'hE0, 32'h3D);
      check("R10 gate cleared forces irq1 low", 64'(irq_out[1]), 64'h0);
      reg_wr(8'hE0, 32'h3F);
      check("R10 gate set restores irq1", 64'(irq_out[1]), 64'h1);
      reg_wr(8'h24, 32'hFFFF_FFC1);
      peek("R9 head holds 6 bits", 8'h24, 32'h1);
      check("R5 irq1 low once head equals tail", 64'(irq_out[1]), 64'h0);

      // R6 group 5, R8 out of range and misaligned offsets
      msi(16'h0014, 32'h55);
      check("R6 group5 address", mem_wr_addr, 64'h1_2345_6500);
      msi(16'h0018, 32'h66);
      check("R8 group 6 dropped", 64'(mem_wr_en), 64'h0);
      msi(16'h0006, 32'h77);
      check("R8 misaligned dropped", 64'(mem_wr_en), 64'h0);
      reg_chk("R8 tail1 unchanged", 8'h28, 32'h1);

      // R4 fill group 2 back to back
      msi_burst(16'h0008, 64, 32'h1000);
      reg_chk("R4 tail2 stops at 63", 8'h48, 32'd63);
      peek("R4 ovf2 set", 8'h4C, 32'h1);
      reg_wr(8'h4C, 32'h0);
      peek("R4 ovf2 sticky on zero write", 8'h4C, 32'h1);
      reg_wr(8'h4C, 32'h1);
      peek("R4 ovf2 cleared", 8'h4C, 32'h0);

      // R3 wrap
      reg_wr(8'h44, 32'd63);
      check("R5 irq2 low when drained", 64'(irq_out[2]), 64'h0);
      msi_burst(16'h0008, 2, 32'h2000);
      reg_chk("R3 tail2 wraps to 1", 8'h48, 32'd1);
      check("R3 irq2 high after wrap", 64'(irq_out[2]), 64'h1);

      // R7 paged layout
      reg_wr(8'h70, 32'h8765_4321);
      reg_wr(8'h74, 32'h0);
      reg_wr(8'hE4, 32'h1);
      msi(16'h3010, 32'hCAFE_0009);
      check("R7 paged address group3", mem_wr_addr, 64'h0000_0000_8765_4000);
      msi(16'h3FFC, 32'hCAFE_000A);
      check("R7 paged address second slot", mem_wr_addr, 64'h0000_0000_8765_4004);
      msi(16'h6000, 32'h1);
      check("R8 paged group 6 dropped", 64'(mem_wr_en), 64'h0);
      reg_chk("R7 tail3", 8'h68, 32'd2);

      repeat (3) @(negedge clk);
      run_cmp = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule